// File: doc/BRIEF.md
# Atomic Conditional-Store Access Checker

This block judges whether a conditional store (an atomic compare-and-swap) may proceed at a given virtual address. It takes the address translation result for that address: a fault code, page read and write permissions, and a page cache attribute. It also takes a 6-bit atomic control word, made of three 2-bit fields, and a configuration flag that says whether a data cache is present. One cycle after a request strobe it presents a registered verdict. The verdict is either pass, or an exception cause together with the faulting virtual address.

Three checks apply in a fixed order. A translation fault comes first. A missing read or write permission comes next. Last comes the atomic-control check, which is chosen by the page's cache attribute. Only the cause of the highest-ranked failing check is reported. The block is placed between the data translation stage and the atomic operation sequencer. The sequencer either raises the reported exception or goes on with the memory operation.

Top module: `acc_chk_atomic`

## Requirements
- R1: Each cycle in which `req_valid` is high produces `rsp_valid` high for exactly the following cycle. `rsp_valid` is low in every other cycle.
- R2: A nonzero `xlat_fault` has the highest rank. It is reported as `rsp_fault`=1 with `rsp_cause` equal to that code and `rsp_vaddr` equal to the request address, whatever the permissions, attribute and control word are.
- R3: A translation fault code equal to the load-prohibited cause (parameter, default 28) is reported as the store-prohibited cause (parameter, default 29). `rsp_cause` never shows the load-prohibited code.
- R4: If `xlat_fault` is zero and the page is not both readable and writable, the store-prohibited cause (default 29) is reported with the address. This check ranks above the atomic-control check.
- R5: When `dcache_present` is 0, every access is checked as a bypass access against control bits 1:0, whatever the page attribute is, isolate included.
- R6: The page attribute codes are: 0 = bypass, which checks control bits 1:0; 1 = write-through, which checks bits 3:2; 2 = write-back, which checks bits 5:4. If the selected 2-bit field is 00, the load/store error cause (parameter, default 3) is reported with the address. Any other field value passes.
- R7: With a data cache present, attribute code 3 (isolate) always reports the load/store error cause with the address.
- R8: With a data cache present, attribute codes 4 to 7 pass whatever the control word is.
- R9: A passing verdict shows `rsp_fault`=0, `rsp_cause`=0 and `rsp_vaddr`=0.
- R10: Synchronous reset clears all outputs to zero. Between requests, `rsp_fault`, `rsp_cause` and `rsp_vaddr` hold their last verdict even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one check per high cycle |
| req_vaddr | input | VA_W (32) | Virtual address of the conditional store |
| xlat_fault | input | CAUSE_W (6) | Translation fault code, 0 = translation succeeded |
| page_rd | input | 1 | Page is readable |
| page_wr | input | 1 | Page is writable |
| page_attr | input | ATTR_W (3) | Page cache attribute code |
| atom_ctl | input | FIELD_W*NUM_FIELDS (6) | Atomic control word, one 2-bit field per cacheable class |
| dcache_present | input | 1 | Data cache configured |
| rsp_valid | output | 1 | Verdict strobe |
| rsp_fault | output | 1 | Verdict is an exception |
| rsp_cause | output | CAUSE_W (6) | Exception cause, 0 on pass |
| rsp_vaddr | output | VA_W (32) | Faulting virtual address, 0 on pass |

## Verification
The hardest situation to reach is one in which several checks fail at once. Only the ranking then decides which cause appears, and a single failing check cannot show that ranking. The stimulus table therefore pairs a translation fault with a zero control field, and a missing permission with a zero bypass field. A second hard case is the no-cache configuration, where the page attribute must be ignored. There, a write-back page and an isolate page are driven with control words whose verdict would flip if the attribute were not overridden. Hold behaviour is checked by changing every input to a failing pattern while the strobe is low and confirming that the verdict does not move.

// File: rtl/acc_chk_pkg.sv
package acc_chk_pkg;
  localparam int ATTR_W = 3;
  localparam logic [ATTR_W-1:0] ATTR_BYPASS = 3'd0;
  localparam logic [ATTR_W-1:0] ATTR_WTHRU  = 3'd1;
  localparam logic [ATTR_W-1:0] ATTR_WBACK  = 3'd2;
  localparam logic [ATTR_W-1:0] ATTR_ISO    = 3'd3;
endpackage

// File: rtl/acc_chk_field_sel.sv
module acc_chk_field_sel
  import acc_chk_pkg::*;
#(
  parameter int FIELD_W    = 2,
  parameter int NUM_FIELDS = 3,
  localparam int CTL_W     = FIELD_W * NUM_FIELDS
) (
  input  logic [ATTR_W-1:0] attr,
  input  logic              dcache_present,
  input  logic [CTL_W-1:0]  ctl,
  output logic              field_err,
  output logic              iso_err
);
  logic [ATTR_W-1:0]     eff_attr;
  logic [NUM_FIELDS-1:0] hit;
  logic [NUM_FIELDS-1:0] zero;

  // Without a data cache every page is treated as bypass.
  assign eff_attr = dcache_present ? attr : ATTR_BYPASS;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign hit[g]  = (eff_attr == ATTR_W'(g));
    assign zero[g] = ~|ctl[g*FIELD_W +: FIELD_W];
  end

  assign field_err = |(hit & zero);
  assign iso_err   = (eff_attr == ATTR_ISO);
endmodule

// File: rtl/acc_chk_prio.sv
module acc_chk_prio #(
  parameter int CAUSE_W = 6,
  parameter logic [CAUSE_W-1:0] C_LOAD_PROHIB  = 6'd28,
  parameter logic [CAUSE_W-1:0] C_STORE_PROHIB = 6'd29,
  parameter logic [CAUSE_W-1:0] C_LS_ERR       = 6'd3
) (
  input  logic [CAUSE_W-1:0] fault_code,
  input  logic               rd_ok,
  input  logic               wr_ok,
  input  logic               field_err,
  input  logic               iso_err,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);
  always_comb begin
    fault = 1'b1;
    cause = '0;
    if (fault_code != '0) begin
      cause = (fault_code == C_LOAD_PROHIB) ? C_STORE_PROHIB : fault_code;
    end else if (!(rd_ok && wr_ok)) begin
      cause = C_STORE_PROHIB;
    end else if (iso_err || field_err) begin
      cause = C_LS_ERR;
    end else begin
      fault = 1'b0;
    end
  end
endmodule

// File: rtl/acc_chk_atomic.sv
module acc_chk_atomic
  import acc_chk_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int CAUSE_W    = 6,
  parameter int FIELD_W    = 2,
  parameter int NUM_FIELDS = 3,
  parameter logic [CAUSE_W-1:0] C_LOAD_PROHIB  = 6'd28,
  parameter logic [CAUSE_W-1:0] C_STORE_PROHIB = 6'd29,
  parameter logic [CAUSE_W-1:0] C_LS_ERR       = 6'd3,
  localparam int CTL_W = FIELD_W * NUM_FIELDS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [CAUSE_W-1:0] xlat_fault,
  input  logic               page_rd,
  input  logic               page_wr,
  input  logic [ATTR_W-1:0]  page_attr,
  input  logic [CTL_W-1:0]   atom_ctl,
  input  logic               dcache_present,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic [VA_W-1:0]    rsp_vaddr
);
  logic               field_err, iso_err;
  logic               nxt_fault;
  logic [CAUSE_W-1:0] nxt_cause;

  acc_chk_field_sel #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_sel (
    .attr(page_attr), .dcache_present(dcache_present), .ctl(atom_ctl),
    .field_err(field_err), .iso_err(iso_err)
  );

  acc_chk_prio #(
    .CAUSE_W(CAUSE_W), .C_LOAD_PROHIB(C_LOAD_PROHIB),
    .C_STORE_PROHIB(C_STORE_PROHIB), .C_LS_ERR(C_LS_ERR)
  ) u_prio (
    .fault_code(xlat_fault), .rd_ok(page_rd), .wr_ok(page_wr),
    .field_err(field_err), .iso_err(iso_err),
    .fault(nxt_fault), .cause(nxt_cause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
      rsp_vaddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= nxt_fault;
        rsp_cause <= nxt_fault ? nxt_cause : '0;
        rsp_vaddr <= nxt_fault ? req_vaddr : '0;
      end
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R1
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R2
  fault_first_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && xlat_fault != '0 && xlat_fault != C_LOAD_PROHIB) |=>
      (rsp_fault && rsp_cause == $past(xlat_fault) && rsp_vaddr == $past(req_vaddr)));
  // R3
  no_load_prohib_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_cause != C_LOAD_PROHIB);
  // R7
  iso_error_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && xlat_fault == '0 && page_rd && page_wr && dcache_present
     && page_attr == ATTR_ISO) |=> (rsp_fault && rsp_cause == C_LS_ERR));
  // R9
  pass_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == '0 && rsp_vaddr == '0));
  // R10
  verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_fault) && $stable(rsp_cause) && $stable(rsp_vaddr)));
endmodule

// File: tb/acc_chk_atomic_test.sv
module acc_chk_atomic_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [5:0]  xlat_fault = '0;
  logic        page_rd = 1'b0, page_wr = 1'b0;
  logic [2:0]  page_attr = '0;
  logic [5:0]  atom_ctl = '0;
  logic        dcache_present = 1'b1;
  logic        rsp_valid, rsp_fault;
  logic [5:0]  rsp_cause;
  logic [31:0] rsp_vaddr;
  int compared = 0, mismatched = 0, cycles = 0;

  always #2 clk = ~clk;

  acc_chk_atomic uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .xlat_fault(xlat_fault), .page_rd(page_rd), .page_wr(page_wr),
    .page_attr(page_attr), .atom_ctl(atom_ctl), .dcache_present(dcache_present),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_vaddr(rsp_vaddr)
  );

  typedef struct packed {
    logic [5:0]  fc;
    logic        rd;
    logic        wr;
    logic [2:0]  attr;
    logic [5:0]  ctl;
    logic        dc;
    logic [31:0] va;
    logic        ef;
    logic [5:0]  ec;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{6'd26, 1'b1, 1'b1, 3'd0, 6'b000000, 1'b1, 32'h1000_0010, 1'b1, 6'd26, 8'd2},  // R2 beats field error
    '{6'd28, 1'b1, 1'b1, 3'd2, 6'b111111, 1'b1, 32'h2000_0020, 1'b1, 6'd29, 8'd3},  // R3 remap
    '{6'd0,  1'b0, 1'b1, 3'd0, 6'b000000, 1'b1, 32'h3000_0030, 1'b1, 6'd29, 8'd4},  // R4 no read
    '{6'd0,  1'b1, 1'b0, 3'd1, 6'b111111, 1'b1, 32'h4000_0040, 1'b1, 6'd29, 8'd4},  // R4 no write
    '{6'd0,  1'b1, 1'b1, 3'd0, 6'b111100, 1'b1, 32'h5000_0050, 1'b1, 6'd3,  8'd6},  // R6 bypass zero
    '{6'd0,  1'b1, 1'b1, 3'd0, 6'b000001, 1'b1, 32'h6000_0060, 1'b0, 6'd0,  8'd6},  // R6 bypass ok
    '{6'd0,  1'b1, 1'b1, 3'd1, 6'b110011, 1'b1, 32'h7000_0070, 1'b1, 6'd3,  8'd6},  // R6 wthru zero
    '{6'd0,  1'b1, 1'b1, 3'd1, 6'b001000, 1'b1, 32'h8000_0080, 1'b0, 6'd0,  8'd6},  // R6 wthru ok
    '{6'd0,  1'b1, 1'b1, 3'd2, 6'b001111, 1'b1, 32'h9000_0090, 1'b1, 6'd3,  8'd6},  // R6 wback zero
    '{6'd0,  1'b1, 1'b1, 3'd2, 6'b100000, 1'b1, 32'hA000_00A0, 1'b0, 6'd0,  8'd6},  // R6 wback ok
    '{6'd0,  1'b1, 1'b1, 3'd3, 6'b111111, 1'b1, 32'hB000_00B0, 1'b1, 6'd3,  8'd7},  // R7 isolate
    '{6'd0,  1'b1, 1'b1, 3'd5, 6'b000000, 1'b1, 32'hC000_00C0, 1'b0, 6'd0,  8'd8},  // R8 other attr
    '{6'd0,  1'b1, 1'b1, 3'd2, 6'b110000, 1'b0, 32'hD000_00D0, 1'b1, 6'd3,  8'd5},  // R5 wback as bypass
    '{6'd0,  1'b1, 1'b1, 3'd3, 6'b000010, 1'b0, 32'hE000_00E0, 1'b0, 6'd0,  8'd5},  // R5 isolate as bypass
    '{6'd0,  1'b1, 1'b1, 3'd1, 6'b000011, 1'b0, 32'hF000_00F0, 1'b0, 6'd0,  8'd5}   // R5 wthru as bypass
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic strobe);
    xlat_fault = v.fc; page_rd = v.rd; page_wr = v.wr; page_attr = v.attr;
    atom_ctl = v.ctl; dcache_present = v.dc; req_vaddr = v.va; req_valid = strobe;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset valid", 64'(rsp_valid), 64'd0);
    chk("R10 reset fault", 64'(rsp_fault), 64'd0);
    chk("R10 reset cause", 64'(rsp_cause), 64'd0);
    chk("R10 reset vaddr", 64'(rsp_vaddr), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("R%0d vec%0d", TBL[i].rq, i);
      drive(TBL[i], 1'b1);
      @(negedge clk);
      req_valid = 1'b0;
      chk({t, " valid"}, 64'(rsp_valid), 64'd1);  // R1
      chk({t, " fault"}, 64'(rsp_fault), 64'(TBL[i].ef));
      chk({t, " cause"}, 64'(rsp_cause), 64'(TBL[i].ec));
      chk({t, " vaddr"}, 64'(rsp_vaddr), TBL[i].ef ? 64'(TBL[i].va) : 64'd0);  // R9 on pass
      @(negedge clk);
      chk({t, " R1 pulse end"}, 64'(rsp_valid), 64'd0);
    end

    // R10 hold: last verdict was pass; drive a failing pattern with strobe low
    drive(TBL[0], 1'b0);
    repeat (2) @(negedge clk);
    chk("R10 hold fault", 64'(rsp_fault), 64'd0);
    chk("R10 hold cause", 64'(rsp_cause), 64'd0);
    chk("R10 hold valid", 64'(rsp_valid), 64'd0);

    // R1 back-to-back requests: two strobes give two consecutive verdicts
    drive(TBL[6], 1'b1);
    @(negedge clk);
    chk("R1 b2b first valid", 64'(rsp_valid), 64'd1);
    chk("R1 b2b first cause", 64'(rsp_cause), 64'd3);
    drive(TBL[2], 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 b2b second valid", 64'(rsp_valid), 64'd1);
    chk("R1 b2b second cause", 64'(rsp_cause), 64'd29);
    chk("R1 b2b second vaddr", 64'(rsp_vaddr), 64'h3000_0030);

    // R10 reset after a fault verdict clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R10 rst fault", 64'(rsp_fault), 64'd0);
    chk("R10 rst vaddr", 64'(rsp_vaddr), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule